// File: doc/BRIEF.md
# UART Receive Line Status Tracker

This block keeps the line status byte that a UART shows to its host. The receiver hands it each character together with three tags: parity error, framing error and break. The block queues the character and its tags in a small receive FIFO. The status byte always reports the tags of the character at the head of that FIFO, which is the next one the host will read. A separate summary bit covers every queued character, not only the head. To keep that bit cheap, the block keeps a running count of tagged entries instead of scanning the FIFO.

The block also keeps a sticky overrun flag and a break indication that is tied to the level of the receive line. It derives the two transmitter-idle bits from the transmit FIFO level and a shift-register-busy input, and it drives a line status interrupt. Baud generation, serialization and the host bus are outside this block. The host reads a character by pulsing `rxPop` and reads the status byte by pulsing `statusRead`.

Top module: `uart_line_status`

## Requirements
- R1: Bit 0 of `lineStatus` is 1 exactly when the receive FIFO holds at least one character. All state takes effect on the clock edge after the strobe that causes it. After reset the FIFO is empty and bits 0 to 4 and bit 7 are 0.
- R2: Bits 2 (parity) and 3 (framing) show the tags of the head character. Both are 0 while the FIFO is empty.
- R3: Bit 7 is 1 while any queued character carries a parity, framing or break tag. It returns to 0 on its own once all tagged characters have been popped.
- R4: A push offered while the FIFO is full, with no pop in the same cycle, discards the character and sets bit 1 (overrun). A cycle with `statusRead` high returns the current byte, and bit 1 clears on that edge. If a new overrun arrives in the same cycle as the read, the set wins.
- R5: A push tagged as break is accepted only when no break is currently held. It then sets bit 4. While bit 4 is set, further break-tagged pushes are ignored entirely. Bit 4 clears on the first edge at which `rxLine` is 1, unless a new break is accepted in that same cycle.
- R6: Bit 5 (holding side empty) is 1 exactly when `txCount` is 0.
- R7: Bit 6 (transmitter empty) is 1 exactly when `txCount` is 0 and `txShiftBusy` is 0.
- R8: `lsIrq` equals `lsiEnable` AND (bit 7 OR bit 1). It fires as soon as a tagged character is queued, wherever that character sits in the FIFO.
- R9: When `fifoMode` is 0 the receive store holds one character. When it is 1 the store holds `RX_DEPTH` characters. The mode may only be changed while the FIFO is empty.
- R10: Characters leave in arrival order, and `rxHeadData` shows the head character (0 when empty). A pop on an empty FIFO has no effect. A push and a pop in the same cycle on a full FIFO both take effect, and no overrun is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxPush | input | 1 | Receiver offers a character this cycle |
| rxData | input | 8 | Offered character |
| rxParErr | input | 1 | Parity error tag of the offered character |
| rxFrmErr | input | 1 | Framing error tag of the offered character |
| rxBrk | input | 1 | Break tag of the offered character |
| rxLine | input | 1 | Sampled receive line level (1 = idle) |
| rxPop | input | 1 | Host reads the head character |
| statusRead | input | 1 | Host reads the status byte |
| fifoMode | input | 1 | 1 = deep receive FIFO, 0 = single holding slot |
| txCount | input | TXC_W | Transmit FIFO fill level |
| txShiftBusy | input | 1 | Transmit shift register holds a character |
| lsiEnable | input | 1 | Line status interrupt enable |
| rxHeadData | output | 8 | Head character of the receive FIFO |
| lineStatus | output | 8 | Status byte, bit positions as in R1 to R7 |
| lsIrq | output | 1 | Line status interrupt |

## Verification
The first sweep pushes all eight combinations of the three tags and then drains the FIFO. This tells apart head-only reporting (bits 2 and 3) from whole-FIFO reporting (bit 7 and the interrupt). Dedicated sequences cover four edge cases:
- filling past capacity, then a status read;
- repeated break pushes while the line stays low, then the line returning high;
- the one-slot mode;
- a full sweep of every transmit level against the busy input.

A long pseudo-random run then mixes pushes, pops, reads, tags and line levels. Its purpose is to catch counter drift between the tagged-entry count and the FIFO contents.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  localparam int DATA_W = 8;

  localparam int B_READY = 0;
  localparam int B_OVR   = 1;
  localparam int B_PAR   = 2;
  localparam int B_FRM   = 3;
  localparam int B_BRK   = 4;
  localparam int B_THRE  = 5;
  localparam int B_TEMT  = 6;
  localparam int B_ERRS  = 7;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              parErr;
    logic              frmErr;
    logic              brkTag;
  } rxEntry_t;

  typedef struct packed {
    logic doPush;
    logic doPop;
    logic setOvr;
    logic clrOvr;
    logic setBrk;
    logic clrBrk;
  } lsrStrobe_t;
endpackage

// File: rtl/lsr_ctrl.sv
module lsr_ctrl
  import lsr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             rxPush,
  input  logic             rxBrk,
  input  logic             rxPop,
  input  logic             rxLine,
  input  logic             statusRead,
  input  logic             fifoMode,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic             breakHeld,
  output lsrStrobe_t       strobe
);
  localparam logic [CNT_W-1:0] CAP_DEEP = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CAP_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] capacity;
  logic isFull, popOk, brkBlocked, offered;

  always_comb begin
    capacity   = fifoMode ? CAP_DEEP : CAP_ONE;
    isFull     = fifoCount >= capacity;
    popOk      = rxPop && (fifoCount != '0);
    // a break already held swallows further break characters (R5)
    brkBlocked = rxPush && rxBrk && breakHeld;
    offered    = rxPush && !brkBlocked;

    strobe        = '0;
    strobe.doPop  = popOk;
    strobe.doPush = offered && (!isFull || popOk);
    strobe.setOvr = offered && isFull && !popOk;
    strobe.clrOvr = statusRead;
    strobe.setBrk = rxPush && rxBrk && !breakHeld;
    strobe.clrBrk = rxLine;
  end
endmodule

// File: rtl/lsr_datapath.sv
module lsr_datapath
  import lsr_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TXC_W = 5,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  lsrStrobe_t        strobe,
  input  rxEntry_t          inEntry,
  input  logic [TXC_W-1:0]  txCount,
  input  logic              txShiftBusy,
  input  logic              lsiEnable,
  output logic [CNT_W-1:0]  fifoCount,
  output logic              breakHeld,
  output logic [DATA_W-1:0] headData,
  output logic [7:0]        lsrValue,
  output logic              lsIrq
);
  rxEntry_t         mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count, errCount;
  logic             ovrFlag, brkFlag;
  rxEntry_t         head;
  logic             headValid, inTagged, headTagged;
  logic             errInc, errDec;

  always_comb begin
    head       = mem[rdPtr];
    headValid  = count != '0;
    inTagged   = inEntry.parErr || inEntry.frmErr || inEntry.brkTag;
    headTagged = head.parErr || head.frmErr || head.brkTag;
    errInc     = strobe.doPush && inTagged;
    errDec     = strobe.doPop && headTagged;
  end

  always_ff @(posedge clk) begin
    if (strobe.doPush) mem[wrPtr] <= inEntry;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      errCount <= '0;
      ovrFlag  <= 1'b0;
      brkFlag  <= 1'b0;
    end else begin
      if (strobe.doPush) wrPtr <= wrPtr + PTR_W'(1);
      if (strobe.doPop)  rdPtr <= rdPtr + PTR_W'(1);
      case ({strobe.doPush, strobe.doPop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
      case ({errInc, errDec})
        2'b10:   errCount <= errCount + CNT_W'(1);
        2'b01:   errCount <= errCount - CNT_W'(1);
        default: errCount <= errCount;
      endcase
      if (strobe.setOvr)      ovrFlag <= 1'b1;
      else if (strobe.clrOvr) ovrFlag <= 1'b0;
      if (strobe.setBrk)      brkFlag <= 1'b1;
      else if (strobe.clrBrk) brkFlag <= 1'b0;
    end
  end

  always_comb begin
    lsrValue          = '0;
    lsrValue[B_READY] = headValid;
    lsrValue[B_OVR]   = ovrFlag;
    lsrValue[B_PAR]   = headValid && head.parErr;
    lsrValue[B_FRM]   = headValid && head.frmErr;
    lsrValue[B_BRK]   = brkFlag;
    lsrValue[B_THRE]  = txCount == '0;
    lsrValue[B_TEMT]  = (txCount == '0) && !txShiftBusy;
    lsrValue[B_ERRS]  = errCount != '0;
    headData          = headValid ? head.data : '0;
    lsIrq             = lsiEnable && (lsrValue[B_ERRS] || ovrFlag);
  end

  assign fifoCount = count;
  assign breakHeld = brkFlag;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH)) else $error("count past depth"); // R10
  AST_ERRCNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    errCount <= count) else $error("tagged count exceeds fill"); // R3
  AST_OVR_SETS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setOvr |=> ovrFlag) else $error("overrun not latched"); // R4
  AST_OVR_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setOvr |=> count == $past(count)) else $error("overrun char stored"); // R4
  AST_OVR_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrOvr && !strobe.setOvr |=> !ovrFlag) else $error("read kept overrun"); // R4
  AST_BRK_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    brkFlag && !strobe.clrBrk && !strobe.doPop |=> count == $past(count) || !$past(inEntry.brkTag))
    else $error("second break stored"); // R5
  AST_TEMT_THRE: assert property (@(posedge clk) disable iff (!rstN)
    lsrValue[B_TEMT] |-> lsrValue[B_THRE]) else $error("TEMT without THRE"); // R7
  AST_IRQ_ERR: assert property (@(posedge clk) disable iff (!rstN)
    lsiEnable && errCount != '0 |-> lsIrq) else $error("missing interrupt"); // R8
endmodule

// File: rtl/uart_line_status.sv
module uart_line_status
  import lsr_pkg::*;
#(
  parameter int RX_DEPTH = 16,
  parameter int TXC_W    = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxPush,
  input  logic [7:0]       rxData,
  input  logic             rxParErr,
  input  logic             rxFrmErr,
  input  logic             rxBrk,
  input  logic             rxLine,
  input  logic             rxPop,
  input  logic             statusRead,
  input  logic             fifoMode,
  input  logic [TXC_W-1:0] txCount,
  input  logic             txShiftBusy,
  input  logic             lsiEnable,
  output logic [7:0]       rxHeadData,
  output logic [7:0]       lineStatus,
  output logic             lsIrq
);
  localparam int CNT_W = $clog2(RX_DEPTH) + 1;

  lsrStrobe_t       strobe;
  rxEntry_t         inEntry;
  logic [CNT_W-1:0] fifoCount;
  logic             breakHeld;

  assign inEntry = '{data: rxData, parErr: rxParErr, frmErr: rxFrmErr, brkTag: rxBrk};

  lsr_ctrl #(.DEPTH(RX_DEPTH)) u_ctrl (
    .rxPush(rxPush), .rxBrk(rxBrk), .rxPop(rxPop), .rxLine(rxLine),
    .statusRead(statusRead), .fifoMode(fifoMode), .fifoCount(fifoCount),
    .breakHeld(breakHeld), .strobe(strobe)
  );

  lsr_datapath #(.DEPTH(RX_DEPTH), .TXC_W(TXC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inEntry(inEntry),
    .txCount(txCount), .txShiftBusy(txShiftBusy), .lsiEnable(lsiEnable),
    .fifoCount(fifoCount), .breakHeld(breakHeld), .headData(rxHeadData),
    .lsrValue(lineStatus), .lsIrq(lsIrq)
  );

  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    rxPop && !lineStatus[0] && !rxPush |=> !lineStatus[0]) else $error("pop on empty"); // R10
  AST_ONE_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    !fifoMode && lineStatus[0] && rxPush && !rxBrk && !rxPop |=> lineStatus[1])
    else $error("one-slot overrun missing"); // R9
endmodule

// File: tb/uart_line_status_bench.sv
module uart_line_status_bench;
  localparam int DEPTH = 4;
  localparam int TXW   = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, rxPush, rxParErr, rxFrmErr, rxBrk, rxLine, rxPop, statusRead;
  logic fifoMode, txShiftBusy, lsiEnable, lsIrq;
  logic [7:0] rxData, rxHeadData, lineStatus;
  logic [TXW-1:0] txCount;

  uart_line_status #(.RX_DEPTH(DEPTH), .TXC_W(TXW)) u_uart_line_status (
    .clk(clk), .rstN(rstN), .rxPush(rxPush), .rxData(rxData), .rxParErr(rxParErr),
    .rxFrmErr(rxFrmErr), .rxBrk(rxBrk), .rxLine(rxLine), .rxPop(rxPop),
    .statusRead(statusRead), .fifoMode(fifoMode), .txCount(txCount),
    .txShiftBusy(txShiftBusy), .lsiEnable(lsiEnable), .rxHeadData(rxHeadData),
    .lineStatus(lineStatus), .lsIrq(lsIrq)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  logic [10:0] mq[$];   // {data[10:3], par[2], frm[1], brk[0]}
  bit mOvr = 0, mBrk = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkAll();
    bit anyTag = 0;
    bit ne = mq.size() > 0;
    foreach (mq[i]) if (mq[i][2:0] != 3'b000) anyTag = 1;
    chk("R1 data ready", 32'(lineStatus[0]), 32'(ne));
    chk("R4 overrun", 32'(lineStatus[1]), 32'(mOvr));
    chk("R2 parity head", 32'(lineStatus[2]), 32'(ne && mq[0][2]));
    chk("R2 framing head", 32'(lineStatus[3]), 32'(ne && mq[0][1]));
    chk("R5 break bit", 32'(lineStatus[4]), 32'(mBrk));
    chk("R6 thre", 32'(lineStatus[5]), 32'(txCount == 0));
    chk("R7 temt", 32'(lineStatus[6]), 32'(txCount == 0 && !txShiftBusy));
    chk("R3 summary", 32'(lineStatus[7]), 32'(anyTag));
    chk("R8 irq", 32'(lsIrq), 32'(lsiEnable && (anyTag || mOvr)));
    chk("R10 head data", 32'(rxHeadData), ne ? 32'(mq[0][10:3]) : 32'd0);
  endtask

  task automatic step(bit push, logic [7:0] d, bit par, bit frm, bit brk,
                      bit line, bit pop, bit rd);
    int cap = fifoMode ? DEPTH : 1;
    bit full = mq.size() >= cap;
    bit popOk = pop && mq.size() > 0;
    bit blk = push && brk && mBrk;
    bit pushOk = push && !blk && (!full || popOk);
    bit ovrSet = push && !blk && full && !popOk;
    rxPush = push; rxData = d; rxParErr = par; rxFrmErr = frm; rxBrk = brk;
    rxLine = line; rxPop = pop; statusRead = rd;
    if (ovrSet) mOvr = 1; else if (rd) mOvr = 0;
    if (push && brk && !mBrk) mBrk = 1; else if (line) mBrk = 0;
    if (popOk) void'(mq.pop_front());
    if (pushOk) mq.push_back({d, par, frm, brk});
    @(negedge clk);
    checkAll();
  endtask

  task automatic idle(bit line = 1);
    step(0, 8'h00, 0, 0, 0, line, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rstN = 0; rxPush = 0; rxData = 0; rxParErr = 0; rxFrmErr = 0; rxBrk = 0;
    rxLine = 1; rxPop = 0; statusRead = 0; fifoMode = 1; txCount = 0;
    txShiftBusy = 0; lsiEnable = 1;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset status", 32'(lineStatus), 32'h60);
    checkAll();

    // R2 R3 R8: every tag combination, head vs whole-FIFO reporting
    for (int g = 0; g < 8; g += DEPTH) begin
      for (int k = 0; k < DEPTH; k++) begin
        int t = g + k;
        step(1, 8'(8'h40 + t), t[2], t[1], t[0], t[0] ? 1'b0 : 1'b1, 0, 0);
        idle();
      end
      for (int k = 0; k < DEPTH; k++) step(0, 0, 0, 0, 0, 1, 1, 0);
      step(0, 0, 0, 0, 0, 1, 1, 0); // R10 pop on empty ignored
    end

    // R4 overrun, simultaneous push/pop when full, read clear
    for (int k = 0; k < DEPTH; k++) step(1, 8'(k), 0, 0, 0, 1, 0, 0);
    step(1, 8'hEE, 1, 0, 0, 1, 0, 0);   // dropped, overrun
    step(1, 8'hA5, 0, 1, 0, 1, 1, 0);   // R10 push+pop on full
    step(1, 8'hEF, 0, 0, 0, 1, 0, 1);   // R4 set wins over read
    idle();
    step(0, 0, 0, 0, 0, 1, 0, 1);       // R4 read clears
    for (int k = 0; k < DEPTH; k++) step(0, 0, 0, 0, 0, 1, 1, 0);

    // R5 single break character per event
    step(1, 8'h00, 0, 1, 1, 0, 0, 0);
    step(1, 8'h00, 0, 1, 1, 0, 0, 0);
    step(1, 8'h00, 0, 1, 1, 0, 0, 0);
    idle(0);
    idle(1);
    step(1, 8'h00, 0, 1, 1, 0, 1, 0);
    idle(1);
    step(0, 0, 0, 0, 0, 1, 1, 0);

    // R9 one-slot mode
    fifoMode = 0;
    step(1, 8'h11, 0, 0, 0, 1, 0, 0);
    step(1, 8'h22, 0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 1, 1, 1);
    step(1, 8'h33, 1, 0, 0, 1, 0, 0);
    step(1, 8'h44, 0, 0, 0, 1, 1, 0);
    step(0, 0, 0, 0, 0, 1, 1, 0);
    fifoMode = 1;

    // R6 R7 transmitter sweep
    for (int c = 0; c < (1 << TXW); c++)
      for (int b = 0; b < 2; b++) begin
        txCount = TXW'(c); txShiftBusy = b[0];
        idle();
      end
    txCount = 0; txShiftBusy = 0;

    // mixed pseudo-random traffic, all requirements
    for (int n = 0; n < 4000; n++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      lsiEnable = lfsr[20];
      txCount = TXW'(lfsr[23:21] & {3{lfsr[24]}});
      txShiftBusy = lfsr[25];
      step(lfsr[0], lfsr[15:8], lfsr[1] & lfsr[2], lfsr[3] & lfsr[4],
           lfsr[5] & lfsr[6] & lfsr[7], lfsr[16] | lfsr[17],
           lfsr[18] & (lfsr[19] | lfsr[26]), lfsr[27] & lfsr[28] & lfsr[29]);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule